// File: doc/BRIEF.md
# System Reset Sequencer

This block orders the recovery of a chip from reset. Three events start a sequence: a power-on pulse, a supply-low flag from an external trip detector, and an overflow of a free-running watchdog counter kept inside the block. Once a sequence starts, the block gates the clocks to the processor and peripherals and counts a long oscillator settling period on the crystal-derived clock. It then enables the clocks, releases the external active-low reset pin, and some cycles later lets the processor leave reset and fetch its start vector.

While the supply-low flag is high, the pin stays driven and the clocks stay off. The settling count starts only on the first cycle after the flag clears. A three-bit cause register records why reset happened. Software clears the register by reading it. The watchdog restarts from zero on every service strobe, and it stays cleared for as long as the processor is held in reset.

Top module: `sys_reset_seq`

## Requirements
- R1: After the last cycle in which a reset source is sampled active, `clk_en` stays low for exactly `STAB_CYCLES` clock edges. It goes high on edge `STAB_CYCLES` after that trigger edge.
- R2: `rst_pin_drive` is 1 from the trigger edge until `PIN_DELAY` edges after `clk_en` rises, and it is 0 from then on. A value of 1 means the pin is pulled low.
- R3: `cpu_rst_n` goes high `CPU_DELAY` edges after `clk_en` rises. It is never high while `rst_pin_drive` is 1.
- R4: A power-on pulse loads `status` with 3'b011. Bit 0 is the power-on cause, bit 1 is the supply-low cause and bit 2 is the watchdog cause. The watchdog bit is cleared.
- R5: While `supply_low` is 1, `rst_pin_drive` is 1 and `clk_en` is 0 on the following edge. The settling count starts at the first edge that samples `supply_low` as 0.
- R6: A supply-low event sets `status` bit 1. The bit is ORed into whatever bits are already held.
- R7: If the processor has been out of reset for 2^`WDOG_BITS` edges with no service strobe, the watchdog overflows. `cpu_rst_n` then falls, `status` bit 2 is set, and a full sequence follows.
- R8: A `wdog_kick` strobe clears the watchdog. Strobes spaced fewer than 2^`WDOG_BITS` cycles apart prevent any watchdog reset.
- R9: If a reset source asserts during a sequence in progress, the sequence restarts from the beginning of the settling count.
- R10: A `status_rd` strobe clears `status` on the next edge. A cause that asserts in the same cycle as the read is still recorded.
- R11: The watchdog overflow strobe lasts one cycle. The watchdog does not advance while `cpu_rst_n` is 0, so a long supply-low hold never sets the watchdog bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived reference clock |
| por_pulse | input | 1 | Power-on reset pulse, active high |
| supply_low | input | 1 | Supply is below the trip level |
| wdog_kick | input | 1 | Watchdog service strobe |
| status_rd | input | 1 | Read strobe for the cause register; clears it |
| clk_en | output | 1 | Enable for the processor and peripheral clocks |
| rst_pin_drive | output | 1 | Open-drain enable; 1 pulls the reset pin low |
| cpu_rst_n | output | 1 | Processor reset, low while held |
| status | output | 3 | Reset causes: bit 2 watchdog, bit 1 supply-low, bit 0 power-on |

## Verification
The bench builds the block with a 20-cycle settling count, a 5-cycle pin offset, a 9-cycle processor offset and a 7-bit watchdog. These small values let the bench compare every cycle of a whole sequence against the expected shape. They also let it reach a watchdog overflow after 128 cycles. A supply-low hold longer than the watchdog period can then show that the watchdog is held during reset. With the default 18-bit watchdog, neither the overflow nor that hold could be reached in a short run.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_STAB = 2'd1,
    PH_POST = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;

  localparam int CAUSE_POR = 0;
  localparam int CAUSE_LVI = 1;
  localparam int CAUSE_COP = 2;

  // Pin is free once the post-settling count reaches the pin offset.
  function automatic logic pin_free(input phase_e ph, input int unsigned cnt,
                                    input int unsigned pin_off);
    return (ph == PH_RUN) || ((ph == PH_POST) && (cnt >= pin_off));
  endfunction

  // Last count value of a window of the given length.
  function automatic int unsigned last_tick(input int unsigned len);
    return len - 1;
  endfunction

endpackage

// File: rtl/rst_phase_ctrl.sv
module rst_phase_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 4096,
  parameter int unsigned PIN_DELAY   = 32,
  parameter int unsigned CPU_DELAY   = 64,
  parameter int unsigned CNT_W       = 13
) (
  input  logic clk,
  input  logic trig,
  input  logic supply_low,
  output logic clk_en,
  output logic pin_drive,
  output logic cpu_run
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (trig) begin
      phase_d = supply_low ? PH_HOLD : PH_STAB;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_HOLD: begin
          phase_d = PH_STAB;
          cnt_d   = '0;
        end
        PH_STAB: begin
          if (cnt_q == CNT_W'(last_tick(STAB_CYCLES))) begin
            phase_d = PH_POST;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_POST: begin
          if (cnt_q == CNT_W'(last_tick(CPU_DELAY))) begin
            phase_d = PH_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          phase_d = PH_RUN;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phase_q   <= phase_d;
    cnt_q     <= cnt_d;
    clk_en    <= (phase_d == PH_POST) || (phase_d == PH_RUN);
    pin_drive <= !pin_free(phase_d, int'(cnt_d), PIN_DELAY);
    cpu_run   <= (phase_d == PH_RUN);
  end

endmodule

// File: rtl/rst_wdog.sv
module rst_wdog #(
  parameter int unsigned WDOG_BITS = 18
) (
  input  logic clk,
  input  logic run,
  input  logic kick,
  output logic overflow
);

  logic [WDOG_BITS-1:0] wcnt_q;

  assign overflow = run && !kick && (&wcnt_q);

  always_ff @(posedge clk) begin
    if (!run || kick) wcnt_q <= '0;
    else              wcnt_q <= wcnt_q + 1'b1;
  end

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  logic       lvi,
  input  logic       cop,
  input  logic       rd,
  output logic [2:0] cause
);

  logic [2:0] fresh;

  always_comb begin
    fresh            = '0;
    fresh[CAUSE_LVI] = lvi;
    fresh[CAUSE_COP] = cop;
  end

  always_ff @(posedge clk) begin
    if (por) begin
      cause            <= '0;
      cause[CAUSE_POR] <= 1'b1;
      cause[CAUSE_LVI] <= 1'b1;
    end else begin
      cause <= (rd ? 3'b000 : cause) | fresh;
    end
  end

endmodule

// File: rtl/sys_reset_seq.sv
module sys_reset_seq #(
  parameter int unsigned STAB_CYCLES = 4096,
  parameter int unsigned PIN_DELAY   = 32,
  parameter int unsigned CPU_DELAY   = 64,
  parameter int unsigned WDOG_BITS   = 18
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       supply_low,
  input  logic       wdog_kick,
  input  logic       status_rd,
  output logic       clk_en,
  output logic       rst_pin_drive,
  output logic       cpu_rst_n,
  output logic [2:0] status
);

  localparam int unsigned LONGEST = (STAB_CYCLES > CPU_DELAY) ? STAB_CYCLES : CPU_DELAY;
  localparam int unsigned CNT_W   = $clog2(LONGEST) + 1;

  logic wdog_ovf;
  logic seq_trig;

  assign seq_trig = por_pulse || supply_low || wdog_ovf;

  rst_phase_ctrl #(
    .STAB_CYCLES(STAB_CYCLES),
    .PIN_DELAY  (PIN_DELAY),
    .CPU_DELAY  (CPU_DELAY),
    .CNT_W      (CNT_W)
  ) u_phase (
    .clk       (clk),
    .trig      (seq_trig),
    .supply_low(supply_low),
    .clk_en    (clk_en),
    .pin_drive (rst_pin_drive),
    .cpu_run   (cpu_rst_n)
  );

  rst_wdog #(
    .WDOG_BITS(WDOG_BITS)
  ) u_wdog (
    .clk     (clk),
    .run     (cpu_rst_n),
    .kick    (wdog_kick),
    .overflow(wdog_ovf)
  );

  rst_cause_reg u_cause (
    .clk  (clk),
    .por  (por_pulse),
    .lvi  (supply_low),
    .cop  (wdog_ovf),
    .rd   (status_rd),
    .cause(status)
  );

endmodule

// File: rtl/sys_reset_seq_chk.sv
module sys_reset_seq_chk (
  input logic       clk,
  input logic       por_pulse,
  input logic       supply_low,
  input logic       wdog_kick,
  input logic       status_rd,
  input logic       clk_en,
  input logic       rst_pin_drive,
  input logic       cpu_rst_n,
  input logic [2:0] status,
  input logic       wdog_ovf
);

  assert_gate_before_pin_R2: assert property (@(posedge clk) disable iff (por_pulse)
    !clk_en |-> rst_pin_drive);

  assert_cpu_after_pin_R3: assert property (@(posedge clk) disable iff (por_pulse)
    cpu_rst_n |-> !rst_pin_drive);

  assert_por_cause_R4: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(por_pulse) |-> (status == 3'b011));

  assert_lvi_hold_R5: assert property (@(posedge clk) disable iff (por_pulse)
    supply_low |=> (rst_pin_drive && !clk_en && !cpu_rst_n));

  assert_lvi_bit_R6: assert property (@(posedge clk) disable iff (por_pulse)
    supply_low |=> status[1]);

  assert_cop_reset_R7: assert property (@(posedge clk) disable iff (por_pulse)
    wdog_ovf |=> (status[2] && !cpu_rst_n));

  assert_kick_R8: assert property (@(posedge clk) disable iff (por_pulse)
    wdog_kick |=> !wdog_ovf);

  assert_read_clear_R10: assert property (@(posedge clk) disable iff (por_pulse)
    (status_rd && !supply_low && !wdog_ovf) |=> (status == 3'b000));

  assert_ovf_pulse_R11: assert property (@(posedge clk) disable iff (por_pulse)
    wdog_ovf |=> !wdog_ovf);

  assert_ovf_running_R11: assert property (@(posedge clk) disable iff (por_pulse)
    wdog_ovf |-> cpu_rst_n);

endmodule

bind sys_reset_seq sys_reset_seq_chk u_chk (
  .clk          (clk),
  .por_pulse    (por_pulse),
  .supply_low   (supply_low),
  .wdog_kick    (wdog_kick),
  .status_rd    (status_rd),
  .clk_en       (clk_en),
  .rst_pin_drive(rst_pin_drive),
  .cpu_rst_n    (cpu_rst_n),
  .status       (status),
  .wdog_ovf     (wdog_ovf)
);

// File: tb/sys_reset_seq_tb.sv
`timescale 1ns/1ps
module sys_reset_seq_tb;

  localparam int S  = 20;
  localparam int P  = 5;
  localparam int C  = 9;
  localparam int WB = 7;

  logic clk = 1'b0;
  logic por_pulse = 1'b1;
  logic supply_low = 1'b0;
  logic wdog_kick = 1'b0;
  logic status_rd = 1'b0;
  logic clk_en, rst_pin_drive, cpu_rst_n;
  logic [2:0] status;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sys_reset_seq #(
    .STAB_CYCLES(S), .PIN_DELAY(P), .CPU_DELAY(C), .WDOG_BITS(WB)
  ) u_dut (
    .clk(clk), .por_pulse(por_pulse), .supply_low(supply_low),
    .wdog_kick(wdog_kick), .status_rd(status_rd), .clk_en(clk_en),
    .rst_pin_drive(rst_pin_drive), .cpu_rst_n(cpu_rst_n), .status(status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called on the negedge just after the trigger edge (k = 0); returns at k = S+C.
  task automatic seq_check(input string tag);
    int bad_en = -1, bad_pin = -1, bad_cpu = -1;
    for (int k = 0; k <= S + C; k++) begin
      if (k > 0) @(negedge clk);
      if (clk_en !== (k >= S) && bad_en < 0)            bad_en = k;
      if (rst_pin_drive !== (k < S + P) && bad_pin < 0) bad_pin = k;
      if (cpu_rst_n !== (k >= S + C) && bad_cpu < 0)    bad_cpu = k;
    end
    check(bad_en < 0,  "R1", {tag, " clk_en first bad cycle"}, bad_en, -1);
    check(bad_pin < 0, "R2", {tag, " pin first bad cycle"}, bad_pin, -1);
    check(bad_cpu < 0, "R3", {tag, " cpu first bad cycle"}, bad_cpu, -1);
  endtask

  task automatic t_power_on();
    repeat (3) @(negedge clk);
    check(rst_pin_drive === 1'b1 && clk_en === 1'b0 && cpu_rst_n === 1'b0, "R2",
          "reset state", {29'd0, rst_pin_drive, clk_en, cpu_rst_n}, 4);
    por_pulse = 1'b0;
    seq_check("power-on");
    check(status === 3'b011, "R4", "cause after power-on", status, 3);
  endtask

  task automatic t_watchdog();
    int n = 0;
    while (cpu_rst_n === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(n == (1 << WB), "R7", "cycles to watchdog reset", n, 1 << WB);
    check(status === 3'b111, "R7", "cause after watchdog", status, 7);
    seq_check("watchdog");
  endtask

  task automatic t_status_read();
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    check(status === 3'b000, "R10", "cause after read", status, 0);
  endtask

  task automatic t_kick();
    bit stayed = 1'b1;
    for (int i = 0; i < 400; i++) begin
      wdog_kick = (i % 100 == 0);
      @(negedge clk);
      if (cpu_rst_n !== 1'b1) stayed = 1'b0;
    end
    wdog_kick = 1'b0;
    check(stayed, "R8", "cpu stays out of reset with service", stayed, 1);
    check(status === 3'b000, "R8", "no watchdog cause", status, 0);
  endtask

  task automatic t_lvi();
    bit held = 1'b1;
    status_rd  = 1'b1;
    supply_low = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    check(status === 3'b010, "R10", "cause set with read same cycle", status, 2);
    for (int i = 0; i < 140; i++) begin
      if (rst_pin_drive !== 1'b1 || clk_en !== 1'b0) held = 1'b0;
      @(negedge clk);
    end
    check(held, "R5", "pin held and clocks off while supply low", held, 1);
    supply_low = 1'b0;
    @(negedge clk);
    seq_check("supply-low");
    check(status === 3'b010, "R11", "no watchdog cause after long hold", status, 2);
    check(status[1] === 1'b1, "R6", "supply-low cause bit", status[1], 1);
  endtask

  task automatic t_restart();
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
    repeat (10) @(negedge clk);
    check(clk_en === 1'b0, "R9", "mid-sequence clocks gated", clk_en, 0);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
    @(negedge clk);
    seq_check("restart R9");
    check(status === 3'b010, "R6", "cause after restart", status, 2);
  endtask

  initial begin
    fork
      begin
        t_power_on();
        t_watchdog();
        t_status_read();
        t_kick();
        t_lvi();
        t_restart();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog timeout: actual 1 expected 0");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule